// File: doc/BRIEF.md
# Wrapping Page Write Buffer

This block collects the data bytes of one serial-bus write session and hands them to a memory array in a single operation. The write engine presents the received memory address and a strobe for each incoming data byte. The first byte of a session fixes the page. Later bytes land at an in-page offset that counts up and wraps inside that page. A commit pulse, given after the bus STOP, writes every loaded byte to the array at once. An abort pulse throws the session away. Abort covers a write-protect rejection and a new START without a STOP.

The array port carries a page number, a full page of data and a per-byte enable mask. Only bytes loaded in the session have their mask bit set, so the other bytes of the page keep their old contents. The array itself is outside the block. It is expected to start with every byte at FFh and to apply the mask on each write strobe.

The controller has three states. IDLE waits for a session. FILL accepts bytes. WRITE drives the array strobe for one cycle. The transitions are: open (IDLE to FILL on the first accepted byte), load (FILL to FILL on each further byte), close (FILL to WRITE on commit), drop (FILL to IDLE on abort) and done (WRITE to IDLE, always after one cycle).

Top module: `pgbuf_wrap`

## Requirements
- R1: After reset the block is in IDLE, `arr_we` is 0 and `arr_mask` is all zeros.
- R2: The first byte accepted in IDLE latches `addr[AW-1:5]` as the page. This page is driven on `arr_page` for the whole session, and `addr` is ignored for every later byte of the session.
- R3: The first byte is stored at offset `addr[4:0]`, and each later byte goes to the previous offset plus one.
- R4: After offset 31 the next byte goes to offset 0 of the same page.
- R5: A byte sent to an offset that was already loaded in the session replaces the earlier value.
- R6: A commit in FILL makes `arr_we` high for exactly one cycle, in the cycle after the commit. In that cycle `arr_page` holds the page, bit i of `arr_mask` is 1 exactly for each loaded offset i, and `arr_data[8*i+7:8*i]` holds the last byte loaded at offset i.
- R7: Bytes of the page whose mask bit is 0 keep their previous array contents. A fresh array reads FFh.
- R8: An abort in FILL discards the session: no write follows, and the next session's mask holds only its own bytes.
- R9: A commit in IDLE has no effect: `arr_we` stays 0.
- R10: When they coincide, abort wins over commit, and commit wins over a byte strobe (the byte is dropped).
- R11: Byte strobes during WRITE are ignored. After WRITE the block is in IDLE with `arr_mask` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Memory address received in the session header |
| byte_vld | input | 1 | One-cycle strobe: a data byte is present |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Pulse after bus STOP: write the buffered bytes |
| abort | input | 1 | Pulse: discard the session |
| arr_we | output | 1 | Array write strobe, one cycle |
| arr_page | output | AW-5 | Page number of the write |
| arr_data | output | 256 | Page data, byte i in bits 8i+7..8i |
| arr_mask | output | 32 | Per-byte write enable |

## Verification
The assertions assume that `byte_vld`, `commit` and `abort` are single-cycle pulses from one write engine. They also assume the engine never issues a commit without a preceding byte, so the WRITE state always sees a non-empty mask. The stimulus drives every input on the falling clock edge. Each strobe is held for exactly one cycle. Simultaneous strobes appear only in the scenarios that test priority. The bench samples outputs on the falling edge and keeps a byte-wide model of the array that applies the mask on each `arr_we`.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } pg_state_t;
endpackage

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      byte_vld,
    input  logic      commit,
    input  logic      abort,
    output pg_state_t state,
    output logic      ld_first,
    output logic      ld_byte,
    output logic      clr,
    output logic      we
);
    pg_state_t state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (byte_vld && !abort && !commit) state_n = ST_FILL;  // open
            ST_FILL: begin
                if (abort)       state_n = ST_IDLE;                          // drop
                else if (commit) state_n = ST_WRITE;                         // close
            end
            ST_WRITE: state_n = ST_IDLE;                                     // done
            default:  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_first = 1'b0;
        ld_byte  = 1'b0;
        clr      = 1'b0;
        we       = 1'b0;
        unique case (state)
            ST_IDLE:  ld_first = byte_vld && !abort && !commit;
            ST_FILL: begin
                ld_byte = byte_vld && !abort && !commit;
                clr     = abort;
            end
            ST_WRITE: begin
                we  = 1'b1;
                clr = 1'b1;
            end
            default: ;
        endcase
    end

    // R6
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    // R10
    abort_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && abort) |=> (state == ST_IDLE));

    // R11
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> (state == ST_IDLE));
endmodule

// File: rtl/pgbuf_ptr.sv
module pgbuf_ptr #(
    parameter int AW = 12,
    parameter int PAGE_BYTES = 32,
    localparam int OW = $clog2(PAGE_BYTES),
    localparam int PW = AW - OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ld_first,
    input  logic          ld_byte,
    output logic [PW-1:0] page_q,
    output logic [OW-1:0] wr_off
);
    logic [OW-1:0] off_q;

    always_comb wr_off = ld_first ? addr[OW-1:0] : off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
        end else begin
            if (ld_first) page_q <= addr[AW-1:OW];
            if (ld_first || ld_byte) off_q <= wr_off + OW'(1);
        end
    end

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_first |=> $stable(page_q));

    // R4
    off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_byte && wr_off == OW'(PAGE_BYTES - 1)) |=> (off_q == '0));
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int PAGE_BYTES = 32,
    localparam int OW = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [OW-1:0]           off,
    input  logic [7:0]              din,
    input  logic                    clr,
    output logic [8*PAGE_BYTES-1:0] data_q,
    output logic [PAGE_BYTES-1:0]   mask_q
);
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        logic hit;
        always_comb hit = ld && (off == OW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[8*i +: 8] <= 8'hFF;
                mask_q[i]        <= 1'b0;
            end else if (clr) begin
                mask_q[i] <= 1'b0;
            end else if (hit) begin
                data_q[8*i +: 8] <= din;
                mask_q[i]        <= 1'b1;
            end
        end
    end

    // R11
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask_q == '0));

    // R3
    mask_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ($countones(mask_q) <= $past($countones(mask_q)) + 1));
endmodule

// File: rtl/pgbuf_wrap.sv
module pgbuf_wrap
    import pgbuf_pkg::*;
#(
    parameter int AW = 12,
    parameter int PAGE_BYTES = 32,
    localparam int OW = $clog2(PAGE_BYTES),
    localparam int PW = AW - OW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_data,
    input  logic                    commit,
    input  logic                    abort,
    output logic                    arr_we,
    output logic [PW-1:0]           arr_page,
    output logic [8*PAGE_BYTES-1:0] arr_data,
    output logic [PAGE_BYTES-1:0]   arr_mask
);
    pg_state_t     state;
    logic          ld_first, ld_byte, clr;
    logic [OW-1:0] wr_off;

    pgbuf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .commit   (commit),
        .abort    (abort),
        .state    (state),
        .ld_first (ld_first),
        .ld_byte  (ld_byte),
        .clr      (clr),
        .we       (arr_we)
    );

    pgbuf_ptr #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .ld_first (ld_first),
        .ld_byte  (ld_byte),
        .page_q   (arr_page),
        .wr_off   (wr_off)
    );

    pgbuf_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld_first || ld_byte),
        .off    (wr_off),
        .din    (byte_data),
        .clr    (clr),
        .data_q (arr_data),
        .mask_q (arr_mask)
    );

    // R6
    we_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_mask != '0));

    // R9
    idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !arr_we);
endmodule

// File: tb/pgbuf_wrap_test.sv
module pgbuf_wrap_test;
    localparam int AW = 12;
    localparam int PB = 32;
    localparam int PW = AW - 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          commit = 1'b0;
    logic          abort = 1'b0;
    logic          arr_we;
    logic [PW-1:0] arr_page;
    logic [8*PB-1:0] arr_data;
    logic [PB-1:0] arr_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] mem [0:(1<<AW)-1];

    always #4 clk = ~clk;

    pgbuf_wrap uut (.*);

    always @(posedge clk)
        if (arr_we)
            for (int i = 0; i < PB; i++)
                if (arr_mask[i]) mem[{arr_page, 5'(i)}] <= arr_data[8*i +: 8];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; byte_data = d; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic pulse_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic t_reset();
        check(arr_we == 1'b0, "R1 we", 64'(arr_we), 0);
        check(arr_mask == '0, "R1 mask", 64'(arr_mask), 0);
    endtask

    task automatic t_single();
        send(12'h123, 8'hA5);
        pulse_commit();
        check(arr_we == 1'b1, "R6 we", 64'(arr_we), 1);
        check(arr_page == 7'h09, "R2 page", 64'(arr_page), 64'h9);
        check(arr_mask == 32'h8, "R3 mask", 64'(arr_mask), 64'h8);
        check(arr_data[8*3 +: 8] == 8'hA5, "R6 data", 64'(arr_data[8*3 +: 8]), 64'hA5);
        @(negedge clk);
        check(arr_we == 1'b0, "R6 pulse", 64'(arr_we), 0);
        check(arr_mask == '0, "R11 cleared", 64'(arr_mask), 0);
        check(mem[12'h123] == 8'hA5, "R6 array", 64'(mem[12'h123]), 64'hA5);
        check(mem[12'h122] == 8'hFF, "R7 untouched", 64'(mem[12'h122]), 64'hFF);
    endtask

    task automatic t_addr_ignored();
        send(12'h040, 8'h11);
        send(12'hFFF, 8'h22);
        send(12'hFFF, 8'h33);
        pulse_commit();
        check(arr_page == 7'h02, "R2 page fixed", 64'(arr_page), 64'h2);
        check(arr_mask == 32'h7, "R3 sequential", 64'(arr_mask), 64'h7);
        check(arr_data[23:0] == 24'h332211, "R3 data", 64'(arr_data[23:0]), 64'h332211);
        @(negedge clk);
    endtask

    task automatic t_wrap();
        send(12'h3FE, 8'hB0);
        send(12'h3FE, 8'hB1);
        send(12'h3FE, 8'hB2);
        send(12'h3FE, 8'hB3);
        pulse_commit();
        check(arr_page == 7'h1F, "R4 page", 64'(arr_page), 64'h1F);
        check(arr_mask == 32'hC000_0003, "R4 mask", 64'(arr_mask), 64'hC0000003);
        check(arr_data[8*0 +: 8] == 8'hB2 && arr_data[8*31 +: 8] == 8'hB1, "R4 data",
              64'({arr_data[8*31 +: 8], arr_data[7:0]}), 64'hB1B2);
        @(negedge clk);
        check(mem[12'h3E0] == 8'hB2 && mem[12'h400] == 8'hFF, "R4 same page",
              64'({mem[12'h3E0], mem[12'h400]}), 64'hB2FF);
    endtask

    task automatic t_overwrite();
        for (int i = 0; i < 33; i++) send(12'h0A0, 8'(i + 8'h40));
        pulse_commit();
        check(arr_mask == '1, "R5 mask", 64'(arr_mask), 64'hFFFFFFFF);
        check(arr_data[7:0] == 8'h60, "R5 replaced", 64'(arr_data[7:0]), 64'h60);
        check(arr_data[15:8] == 8'h41, "R5 kept", 64'(arr_data[15:8]), 64'h41);
        @(negedge clk);
    endtask

    task automatic t_abort();
        send(12'h200, 8'h01);
        send(12'h200, 8'h02);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(arr_mask == '0, "R8 mask dropped", 64'(arr_mask), 0);
        pulse_commit();
        check(arr_we == 1'b0, "R8 no write", 64'(arr_we), 0);
        send(12'h205, 8'h55);
        pulse_commit();
        check(arr_mask == 32'h20, "R8 fresh mask", 64'(arr_mask), 64'h20);
        @(negedge clk);
        check(mem[12'h200] == 8'hFF, "R8 discarded", 64'(mem[12'h200]), 64'hFF);
    endtask

    task automatic t_idle_commit();
        pulse_commit();
        check(arr_we == 1'b0, "R9 idle commit", 64'(arr_we), 0);
        @(negedge clk);
        check(arr_we == 1'b0, "R9 still idle", 64'(arr_we), 0);
    endtask

    task automatic t_priority();
        send(12'h300, 8'h77);
        abort = 1'b1; commit = 1'b1;
        @(negedge clk);
        abort = 1'b0; commit = 1'b0;
        check(arr_we == 1'b0, "R10 abort wins", 64'(arr_we), 0);
        send(12'h304, 8'h44);
        addr = 12'h304; byte_data = 8'h99; byte_vld = 1'b1; commit = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; commit = 1'b0;
        check(arr_mask == 32'h10, "R10 byte dropped", 64'(arr_mask), 64'h10);
        check(arr_data[8*4 +: 8] == 8'h44, "R10 data", 64'(arr_data[8*4 +: 8]), 64'h44);
        @(negedge clk);
    endtask

    task automatic t_write_ignore();
        send(12'h500, 8'hC3);
        pulse_commit();
        check(arr_we == 1'b1, "R11 write", 64'(arr_we), 1);
        send(12'h501, 8'hD4);
        check(arr_mask == '0, "R11 ignored", 64'(arr_mask), 0);
        pulse_commit();
        check(arr_we == 1'b0, "R11 no session", 64'(arr_we), 0);
        @(negedge clk);
        check(mem[12'h501] == 8'hFF, "R11 array", 64'(mem[12'h501]), 64'hFF);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_addr_ignored();
        t_wrap();
        t_overwrite();
        t_abort();
        t_idle_commit();
        t_priority();
        t_write_ignore();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule